// File: doc/BRIEF.md
# Lane-Masked Load Return Formatter

This block sits on the return path of a vector memory unit. When a load or a value-returning atomic comes back, its raw data arrives as one packed buffer of memory-sized elements. The formatter widens every element to the width of a destination register and emits register writes. Integer elements are zero- or sign-extended. Half and single precision elements are converted exactly to the wider floating-point format.

A request is accepted with a one-cycle `start` pulse, and the block captures all of its inputs at that edge. On each cycle that follows, it presents one destination register. The write carries the register index, a per-lane enable taken from the execution mask, and one widened value per lane. Registers go out in order k = 0, 1, ... up to the register count minus one, and `done` marks the last of them.

Two kinds of request are refused. One is a request whose total element size is over the configured limit. The other is a request whose memory type cannot land in the chosen register width. A refused request produces a one-cycle `err` pulse and no writes.

Top module: `load_return_fmt`

## Requirements
- R1: After reset, `busy`, `wr_valid`, `done` and `err` are all low.
- R2: An accepted request produces exactly `reg_cnt` consecutive write cycles. The first is the cycle after the `start` edge, one register index k is presented per cycle, and k rises from 0. `done` is high only in the cycle of the last register, and `wr_valid` falls right after it.
- R3: When `reg_cnt` is at most LIST_THRESH (default 2), the destination index for register k is `base_reg + k`.
- R4: When `reg_cnt` exceeds LIST_THRESH, the destination index for register k is `reg_list[k*RIDX_W +: RIDX_W]`.
- R5: `wr_lane_en` equals the captured `exec_mask` during write cycles and is zero otherwise, so masked-off lanes are never written.
- R6: For register k and lane i, the element is read at bit offset (k*LANES + i) * S of `data_buf`, where S is the element size in bits. Lane i's result appears on `wr_data[i*64 +: 64]`.
- R7: The unsigned codes are U8=0, U16=1, U32=2 and U64=3. These are zero-extended.
- R8: The signed codes are S8=4, S16=5, S32=6 and S64=7. These are sign-extended to the register width. `wide_reg`=0 selects 32-bit registers, whose upper 32 bits of `wr_data` read zero. `wide_reg`=1 selects 64-bit registers.
- R9: Code F16=8 with `wide_reg`=0 gives the exact single-precision value. This holds for subnormals, zeros and infinities. A NaN becomes a quiet NaN that keeps the low payload bits. Code F32=9 with `wide_reg`=0 passes through unchanged.
- R10: With `wide_reg`=1, F16 and F32 are widened exactly to double precision, again with quiet NaNs. F64=10 passes through unchanged.
- R11: A `start` with `reg_cnt` of zero, above MAX_REGS, or with S * `reg_cnt` above MAX_BITS (default 128) causes `err` to be high for the one cycle after the edge, and no write occurs.
- R12: Codes 11 to 15 are refused with `err`. So are U64, S64 and F64 when `wide_reg`=0.
- R13: A `start` that arrives while `busy` is high is ignored, and the running sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe; captures all request inputs |
| mem_type | input | 4 | Memory element type code |
| wide_reg | input | 1 | 0: 32-bit registers, 1: 64-bit registers |
| reg_cnt | input | CNT_W (3) | Number of destination registers |
| base_reg | input | RIDX_W (8) | First destination index for short requests |
| reg_list | input | MAX_REGS*RIDX_W (32) | Explicit destination indices for long requests |
| data_buf | input | MAX_BITS*LANES (512) | Packed returned elements |
| exec_mask | input | LANES (4) | Per-lane execution mask |
| busy | output | 1 | Sequence in progress |
| wr_valid | output | 1 | A register write is presented |
| wr_reg | output | RIDX_W (8) | Destination register index |
| wr_lane_en | output | LANES (4) | Per-lane write enable |
| wr_data | output | LANES*64 (256) | Widened value per lane |
| done | output | 1 | Last register of the request |
| err | output | 1 | Request refused |

## Verification
The bench aims at the floating-point edges first. It drives the smallest and largest half-precision subnormals, signed zero, both infinities, signalling NaNs and a plain value with a full mantissa. A converter that skipped normalisation would give denormal or zero results, and one that left NaNs untouched would return a signalling pattern. For sign extension it uses 0x7F and 0x80 boundaries at both register widths, where a wrong extension length leaks ones into the upper half of a 32-bit result. Element addressing is tested with a distinct value in every slot, so a stride mix-up between lanes and registers shows up as a swapped value. Further cases cover the exact 128-bit size limit against one register more, the switch from base-plus-k indices to the explicit list, and a second `start` arriving mid-sequence.

// File: rtl/ldfmt_pkg.sv
package ldfmt_pkg;

    typedef enum logic [3:0] {
        MK_U8  = 4'd0,
        MK_U16 = 4'd1,
        MK_U32 = 4'd2,
        MK_U64 = 4'd3,
        MK_S8  = 4'd4,
        MK_S16 = 4'd5,
        MK_S32 = 4'd6,
        MK_S64 = 4'd7,
        MK_F16 = 4'd8,
        MK_F32 = 4'd9,
        MK_F64 = 4'd10
    } mem_kind_e;

    typedef struct packed {
        mem_kind_e kind;
        logic      wide;
    } fmt_cfg_t;

    function automatic logic [7:0] elem_bits(input mem_kind_e k);
        case (k)
            MK_U8, MK_S8:          return 8'd8;
            MK_U16, MK_S16, MK_F16: return 8'd16;
            MK_U32, MK_S32, MK_F32: return 8'd32;
            default:               return 8'd64;
        endcase
    endfunction

    function automatic logic kind_fits(input logic [3:0] code, input logic wide);
        if (code > 4'd10) return 1'b0;
        if (!wide && (code == MK_U64 || code == MK_S64 || code == MK_F64)) return 1'b0;
        return 1'b1;
    endfunction

    // exact half -> single widening
    function automatic logic [31:0] half_to_single(input logic [15:0] h);
        logic        s;
        logic [4:0]  e;
        logic [9:0]  m;
        logic [10:0] norm;
        int          p;
        s = h[15];
        e = h[14:10];
        m = h[9:0];
        p = 0;
        if (e == 5'd0) begin
            if (m == 10'd0) return {s, 31'd0};
            for (int b = 0; b < 10; b++) if (m[b]) p = b;
            norm = {1'b0, m} << (10 - p);
            return {s, 8'(p + 103), norm[9:0], 13'd0};
        end
        if (e == 5'd31) return {s, 8'hFF, (m != 10'd0), m[8:0], 13'd0};
        return {s, {3'd0, e} + 8'd112, m, 13'd0};
    endfunction

    // exact single -> double widening
    function automatic logic [63:0] single_to_double(input logic [31:0] f);
        logic        s;
        logic [7:0]  e;
        logic [22:0] m;
        logic [23:0] norm;
        int          p;
        s = f[31];
        e = f[30:23];
        m = f[22:0];
        p = 0;
        if (e == 8'd0) begin
            if (m == 23'd0) return {s, 63'd0};
            for (int b = 0; b < 23; b++) if (m[b]) p = b;
            norm = {1'b0, m} << (23 - p);
            return {s, 11'(p + 874), norm[22:0], 29'd0};
        end
        if (e == 8'hFF) return {s, 11'h7FF, (m != 23'd0), m[21:0], 29'd0};
        return {s, {3'd0, e} + 11'd896, m, 29'd0};
    endfunction

endpackage

// File: rtl/ldfmt_conv.sv
module ldfmt_conv
    import ldfmt_pkg::*;
(
    input  fmt_cfg_t    cfg,
    input  logic [63:0] raw,
    output logic [63:0] value
);
    logic [63:0] ext;

    always_comb begin
        case (cfg.kind)
            MK_U8:   ext = {56'd0, raw[7:0]};
            MK_U16:  ext = {48'd0, raw[15:0]};
            MK_U32:  ext = {32'd0, raw[31:0]};
            MK_S8:   ext = {{56{raw[7]}}, raw[7:0]};
            MK_S16:  ext = {{48{raw[15]}}, raw[15:0]};
            MK_S32:  ext = {{32{raw[31]}}, raw[31:0]};
            MK_F16:  ext = cfg.wide ? single_to_double(half_to_single(raw[15:0]))
                                    : {32'd0, half_to_single(raw[15:0])};
            MK_F32:  ext = cfg.wide ? single_to_double(raw[31:0]) : {32'd0, raw[31:0]};
            default: ext = raw;
        endcase
        value = cfg.wide ? ext : {32'd0, ext[31:0]};
    end
endmodule

// File: rtl/ldfmt_ctrl.sv
module ldfmt_ctrl
    import ldfmt_pkg::*;
#(
    parameter int LANES       = 4,
    parameter int MAX_REGS    = 4,
    parameter int MAX_BITS    = 128,
    parameter int LIST_THRESH = 2,
    parameter int RIDX_W      = 8,
    parameter int CNT_W       = 3,
    parameter int BUF_W       = 512
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start,
    input  logic [3:0]                 kind_in,
    input  logic                       wide_in,
    input  logic [CNT_W-1:0]           cnt_in,
    input  logic [RIDX_W-1:0]          base_in,
    input  logic [MAX_REGS*RIDX_W-1:0] list_in,
    input  logic [BUF_W-1:0]           buf_in,
    input  logic [LANES-1:0]           mask_in,
    output logic                       busy,
    output logic [CNT_W-1:0]           k,
    output logic                       done,
    output logic                       err,
    output fmt_cfg_t                   cfg_q,
    output logic [RIDX_W-1:0]          dst_reg,
    output logic [LANES-1:0]           mask_q,
    output logic [BUF_W-1:0]           buf_q
);
    logic [CNT_W-1:0]           cnt_q;
    logic [RIDX_W-1:0]          base_q;
    logic [MAX_REGS*RIDX_W-1:0] list_q;
    logic [15:0]                total_bits;
    logic                       refuse;

    always_comb begin
        total_bits = 16'(elem_bits(mem_kind_e'(kind_in))) * 16'(cnt_in);
        refuse = (cnt_in == '0) || (int'(cnt_in) > MAX_REGS) ||
                 (int'(total_bits) > MAX_BITS) || !kind_fits(kind_in, wide_in);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            k      <= '0;
            err    <= 1'b0;
            cnt_q  <= '0;
            base_q <= '0;
            list_q <= '0;
            buf_q  <= '0;
            mask_q <= '0;
            cfg_q  <= '{kind: MK_U8, wide: 1'b0};
        end else begin
            err <= 1'b0;
            if (busy) begin
                if (done) busy <= 1'b0;
                else      k    <= k + 1'b1;
            end else if (start) begin
                if (refuse) begin
                    err <= 1'b1;
                end else begin
                    busy   <= 1'b1;
                    k      <= '0;
                    cnt_q  <= cnt_in;
                    base_q <= base_in;
                    list_q <= list_in;
                    buf_q  <= buf_in;
                    mask_q <= mask_in;
                    cfg_q  <= '{kind: mem_kind_e'(kind_in), wide: wide_in};
                end
            end
        end
    end

    always_comb begin
        done = busy && (k == cnt_q - 1'b1);
        if (int'(cnt_q) > LIST_THRESH)
            dst_reg = list_q[int'(k)*RIDX_W +: RIDX_W];
        else
            dst_reg = base_q + RIDX_W'(k);
    end
endmodule

// File: rtl/load_return_fmt.sv
module load_return_fmt
    import ldfmt_pkg::*;
#(
    parameter int LANES       = 4,
    parameter int MAX_REGS    = 4,
    parameter int MAX_BITS    = 128,
    parameter int LIST_THRESH = 2,
    parameter int RIDX_W      = 8,
    localparam int CNT_W      = $clog2(MAX_REGS + 1),
    localparam int BUF_W      = MAX_BITS * LANES
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start,
    input  logic [3:0]                 mem_type,
    input  logic                       wide_reg,
    input  logic [CNT_W-1:0]           reg_cnt,
    input  logic [RIDX_W-1:0]          base_reg,
    input  logic [MAX_REGS*RIDX_W-1:0] reg_list,
    input  logic [BUF_W-1:0]           data_buf,
    input  logic [LANES-1:0]           exec_mask,
    output logic                       busy,
    output logic                       wr_valid,
    output logic [RIDX_W-1:0]          wr_reg,
    output logic [LANES-1:0]           wr_lane_en,
    output logic [LANES*64-1:0]        wr_data,
    output logic                       done,
    output logic                       err
);
    fmt_cfg_t         cfg_q;
    logic [CNT_W-1:0] k;
    logic [LANES-1:0] mask_q;
    logic [BUF_W-1:0] buf_q;
    logic [31:0]      esize;

    ldfmt_ctrl #(
        .LANES(LANES), .MAX_REGS(MAX_REGS), .MAX_BITS(MAX_BITS),
        .LIST_THRESH(LIST_THRESH), .RIDX_W(RIDX_W), .CNT_W(CNT_W), .BUF_W(BUF_W)
    ) u_ctrl (
        .clk(clk), .rst(rst), .start(start),
        .kind_in(mem_type), .wide_in(wide_reg), .cnt_in(reg_cnt),
        .base_in(base_reg), .list_in(reg_list), .buf_in(data_buf), .mask_in(exec_mask),
        .busy(busy), .k(k), .done(done), .err(err),
        .cfg_q(cfg_q), .dst_reg(wr_reg), .mask_q(mask_q), .buf_q(buf_q)
    );

    assign esize      = 32'(elem_bits(cfg_q.kind));
    assign wr_valid   = busy;
    assign wr_lane_en = busy ? mask_q : '0;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [31:0] off;
        logic [63:0] raw;
        assign off = (32'(k) * 32'(LANES) + 32'(i)) * esize;
        assign raw = 64'(buf_q >> off);
        ldfmt_conv u_conv (
            .cfg(cfg_q),
            .raw(raw),
            .value(wr_data[i*64 +: 64])
        );
    end
endmodule

// File: rtl/load_return_fmt_chk.sv
module load_return_fmt_chk #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             busy,
    input logic             wr_valid,
    input logic [LANES-1:0] wr_lane_en,
    input logic             done,
    input logic             err
);
    // R2
    done_in_write_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> wr_valid);

    // R2
    done_ends_seq_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    // R11
    err_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> !wr_valid);

    // R11
    err_after_start_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> ($past(start) && !$past(busy)));

    // R5
    idle_lanes_off_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_valid |-> (wr_lane_en == '0));

    // R13
    busy_from_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));
endmodule

bind load_return_fmt load_return_fmt_chk #(.LANES(LANES)) u_chk (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .wr_valid(wr_valid),
    .wr_lane_en(wr_lane_en), .done(done), .err(err)
);

// File: tb/load_return_fmt_test.sv
`timescale 1ns/1ps
module load_return_fmt_test;
    localparam int LANES = 4;
    localparam int BUF_W = 512;
    localparam int NV    = 29;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [3:0]   mem_type = '0;
    logic         wide_reg = 1'b0;
    logic [2:0]   reg_cnt = '0;
    logic [7:0]   base_reg = '0;
    logic [31:0]  reg_list = '0;
    logic [511:0] data_buf = '0;
    logic [3:0]   exec_mask = '0;
    logic         busy, wr_valid, done, err;
    logic [7:0]   wr_reg;
    logic [3:0]   wr_lane_en;
    logic [255:0] wr_data;

    int nchk = 0;
    int nbad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    load_return_fmt uut (
        .clk(clk), .rst(rst), .start(start), .mem_type(mem_type), .wide_reg(wide_reg),
        .reg_cnt(reg_cnt), .base_reg(base_reg), .reg_list(reg_list), .data_buf(data_buf),
        .exec_mask(exec_mask), .busy(busy), .wr_valid(wr_valid), .wr_reg(wr_reg),
        .wr_lane_en(wr_lane_en), .wr_data(wr_data), .done(done), .err(err)
    );

    // {type, wide, element, expected register value}
    localparam logic [132:0] VEC [NV] = '{
        {4'd0, 1'b0, 64'hF0, 64'hF0},
        {4'd4, 1'b0, 64'hF0, 64'hFFFFFFF0},
        {4'd4, 1'b1, 64'hF0, 64'hFFFFFFFFFFFFFFF0},
        {4'd4, 1'b0, 64'h7F, 64'h7F},
        {4'd1, 1'b1, 64'h8001, 64'h8001},
        {4'd5, 1'b1, 64'h8001, 64'hFFFFFFFFFFFF8001},
        {4'd2, 1'b1, 64'h80000000, 64'h80000000},
        {4'd6, 1'b1, 64'h80000000, 64'hFFFFFFFF80000000},
        {4'd6, 1'b0, 64'h80000000, 64'h80000000},
        {4'd3, 1'b1, 64'h123456789ABCDEF0, 64'h123456789ABCDEF0},
        {4'd7, 1'b1, 64'h8000000000000001, 64'h8000000000000001},
        {4'd8, 1'b0, 64'h3C00, 64'h3F800000},
        {4'd8, 1'b0, 64'hC000, 64'hC0000000},
        {4'd8, 1'b0, 64'h0001, 64'h33800000},
        {4'd8, 1'b0, 64'h03FF, 64'h387FC000},
        {4'd8, 1'b0, 64'h7C00, 64'h7F800000},
        {4'd8, 1'b0, 64'hFC00, 64'hFF800000},
        {4'd8, 1'b0, 64'h7C01, 64'h7FC02000},
        {4'd8, 1'b0, 64'h8000, 64'h80000000},
        {4'd9, 1'b0, 64'h12345678, 64'h12345678},
        {4'd8, 1'b1, 64'h3C00, 64'h3FF0000000000000},
        {4'd8, 1'b1, 64'h0001, 64'h3E70000000000000},
        {4'd8, 1'b1, 64'h7E00, 64'h7FF8000000000000},
        {4'd9, 1'b1, 64'h3F800000, 64'h3FF0000000000000},
        {4'd9, 1'b1, 64'h00000001, 64'h36A0000000000000},
        {4'd9, 1'b1, 64'h7F800001, 64'h7FF8000020000000},
        {4'd9, 1'b1, 64'hFF800000, 64'hFFF0000000000000},
        {4'd9, 1'b1, 64'hC0490FDB, 64'hC00921FB60000000},
        {4'd10, 1'b1, 64'h123456789ABCDEF0, 64'h123456789ABCDEF0}
    };

    function automatic int esz(input logic [3:0] t);
        case (t)
            4'd0, 4'd4:       return 8;
            4'd1, 4'd5, 4'd8: return 16;
            4'd2, 4'd6, 4'd9: return 32;
            default:          return 64;
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] t, input logic w);
        if (t < 4'd4) return "R7";
        if (t < 4'd8) return "R8";
        if (w) return "R10";
        return "R9";
    endfunction

    function automatic logic [511:0] place(input logic [511:0] b, input int slot,
                                           input int es, input logic [63:0] v);
        logic [63:0] m;
        m = (es == 64) ? '1 : ((64'd1 << es) - 64'd1);
        return b | (512'(v & m) << (slot * es));
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic launch(input logic [3:0] t, input logic w, input logic [2:0] c,
                          input logic [7:0] b, input logic [31:0] l,
                          input logic [511:0] d, input logic [3:0] m);
        @(negedge clk);
        mem_type = t; wide_reg = w; reg_cnt = c; base_reg = b;
        reg_list = l; data_buf = d; exec_mask = m; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        #(4 * 100000);
        if (!finished) begin
            nchk++;
            nbad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

    initial begin
        logic [511:0] b;
        bit           ok;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(!busy && !wr_valid && !done && !err, "R1", {busy, wr_valid, done, err}, 0);

        // table: one register, all lanes, conversions R7 R8 R9 R10
        for (int v = 0; v < NV; v++) begin
            b = '0;
            for (int i = 0; i < LANES; i++) b = place(b, i, esz(VEC[v][132:129]), VEC[v][127:64]);
            launch(VEC[v][132:129], VEC[v][128], 3'd1, 8'd5, '0, b, 4'hF);
            ok = wr_valid && done && (wr_reg == 8'd5) && (wr_lane_en == 4'hF);
            for (int i = 0; i < LANES; i++) ok = ok && (wr_data[i*64 +: 64] == VEC[v][63:0]);
            check(ok, req_of(VEC[v][132:129], VEC[v][128]), wr_data[63:0], VEC[v][63:0]);
        end

        // R6 R3 R2: U8, two registers, distinct slots
        b = '0;
        for (int j = 0; j < 8; j++) b = place(b, j, 8, 64'(j + 1));
        launch(4'd0, 1'b0, 3'd2, 8'd10, '0, b, 4'hF);
        for (int k = 0; k < 2; k++) begin
            check(wr_reg == 8'(10 + k), "R3", wr_reg, 64'(10 + k));
            check(wr_valid && (done == (k == 1)), "R2", {wr_valid, done}, {1'b1, k == 1});
            for (int i = 0; i < LANES; i++)
                check(wr_data[i*64 +: 64] == 64'(k*4 + i + 1), "R6",
                      wr_data[i*64 +: 64], 64'(k*4 + i + 1));
            @(negedge clk);
        end
        check(!wr_valid && !busy, "R2", wr_valid, 0);

        // R4: four registers from the list
        b = '0;
        for (int j = 0; j < 16; j++) b = place(b, j, 32, 64'(32'h1000 + j));
        launch(4'd2, 1'b0, 3'd4, 8'd0, {8'd42, 8'd250, 8'd3, 8'd7}, b, 4'hF);
        for (int k = 0; k < 4; k++) begin
            logic [7:0] er;
            er = (k == 0) ? 8'd7 : (k == 1) ? 8'd3 : (k == 2) ? 8'd250 : 8'd42;
            check(wr_valid && wr_reg == er, "R4", wr_reg, er);
            for (int i = 0; i < LANES; i++)
                check(wr_data[i*64 +: 64] == 64'(32'h1000 + k*4 + i), "R6",
                      wr_data[i*64 +: 64], 64'(32'h1000 + k*4 + i));
            check(done == (k == 3), "R2", done, k == 3);
            @(negedge clk);
        end

        // R5: mask 0101 on S16 into 64-bit registers
        b = '0;
        for (int i = 0; i < LANES; i++) b = place(b, i, 16, 64'(16'h8000 + i));
        launch(4'd5, 1'b1, 3'd1, 8'd1, '0, b, 4'b0101);
        check(wr_lane_en == 4'b0101, "R5", wr_lane_en, 4'b0101);
        check(wr_data[63:0] == 64'hFFFFFFFFFFFF8000 && wr_data[191:128] == 64'hFFFFFFFFFFFF8002,
              "R5", wr_data[191:128], 64'hFFFFFFFFFFFF8002);
        @(negedge clk);
        check(wr_lane_en == 4'b0000, "R5", wr_lane_en, 0);

        // R11 boundary: exactly 128 bits accepted
        b = '0;
        for (int j = 0; j < 8; j++) b = place(b, j, 64, 64'hA000_0000_0000_0000 + 64'(j));
        launch(4'd3, 1'b1, 3'd2, 8'd20, '0, b, 4'hF);
        check(wr_valid && !err && wr_data[255:192] == 64'hA000_0000_0000_0003, "R11",
              wr_data[255:192], 64'hA000_0000_0000_0003);
        @(negedge clk);
        check(done && wr_data[63:0] == 64'hA000_0000_0000_0004, "R6",
              wr_data[63:0], 64'hA000_0000_0000_0004);
        @(negedge clk);

        // R11: one register too many, and zero count
        launch(4'd3, 1'b1, 3'd3, 8'd0, '0, b, 4'hF);
        check(err && !wr_valid && !busy, "R11", {err, wr_valid, busy}, 3'b100);
        @(negedge clk);
        check(!err && !wr_valid, "R11", {err, wr_valid}, 0);
        launch(4'd0, 1'b0, 3'd0, 8'd0, '0, b, 4'hF);
        check(err && !wr_valid, "R11", {err, wr_valid}, 2'b10);

        // R12: 64-bit type into 32-bit register, undefined code
        launch(4'd3, 1'b0, 3'd1, 8'd0, '0, b, 4'hF);
        check(err && !wr_valid, "R12", {err, wr_valid}, 2'b10);
        launch(4'd12, 1'b1, 3'd1, 8'd0, '0, b, 4'hF);
        check(err && !wr_valid, "R12", {err, wr_valid}, 2'b10);

        // R13: second start while busy is ignored
        b = '0;
        for (int j = 0; j < 16; j++) b = place(b, j, 8, 64'(j));
        launch(4'd0, 1'b0, 3'd4, 8'd0, {8'd4, 8'd3, 8'd2, 8'd1}, b, 4'hF);
        check(wr_reg == 8'd1, "R13", wr_reg, 1);
        mem_type = 4'd0; reg_cnt = 3'd1; base_reg = 8'd99; reg_list = {4{8'd9}};
        exec_mask = 4'h0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 1; k < 4; k++) begin
            check(wr_valid && wr_reg == 8'(k + 1) && wr_lane_en == 4'hF &&
                  wr_data[64 +: 64] == 64'(k*4 + 1), "R13", wr_reg, 64'(k + 1));
            @(negedge clk);
        end
        check(!busy && !wr_valid && !err, "R13", {busy, wr_valid, err}, 0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule